// File: doc/BRIEF.md
# Segmented Memory Bus Cycle Sequencer

This block is the bus-master engine of a processor that talks to memory over a multiplexed address/data bus with a separate segment field. The core side issues a request: an access kind, a segment number, an offset, write data and a count of internal extension clocks. The sequencer then drives one external memory cycle. The segment number goes out one clock ahead of the offset, which gives an external address translation unit time to work. The offset appears with a low-going address strobe, and a data strobe follows. The cycle ends with a one-clock completion pulse. Read data is returned with that pulse.

A slow memory stretches the cycle by pulling an asynchronous hold input low. That input is synchronized to the bus clock before the sequencer sees it. No cycle may run longer than ten clocks, so that bus requests are answered quickly. If the hold input would push a cycle past that limit, the sequencer ends the cycle at ten clocks and reports a timeout. The translation unit can also report a fault during an access. The sequencer remembers the fault, and it marks the next cycle it runs as a fault-acknowledge cycle.

Top module: `segbus_seq`

## Requirements
- R1: After synchronous reset, and in every idle clock, the outputs are: both strobes high, `rd_wr_n` high, `bus_status` 4'b0000, `ad_oe` low, `seg_o` zero, `req_ready` high, `done` low, `timeout_err` low, `fault_pend` low.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both high. In the next clock (the segment clock) `seg_o` carries the segment and `addr_stb_n` is high. In the clock after that (T1), `addr_stb_n` is low for exactly one clock, with the offset on `ad_out` and `ad_oe` high. `seg_o` stays unchanged from the segment clock through T1.
- R3: `req_xtra` gives the number of internal extension clocks. Values above 5 are treated as 5. These clocks follow T1 and still carry the offset. `data_stb_n` is high in all of them. It goes low in T2, which is the clock right after them, and stays low through T3.
- R4: `req_kind` encodes the access: 2'b00 is an instruction fetch (status 4'b1100), 2'b01 and 2'b11 are data reads (status 4'b1000), and 2'b10 is a data write (status 4'b1000, `rd_wr_n` low). `bus_status` and `rd_wr_n` are valid from the segment clock and do not change until the cycle completes.
- R5: An instruction fetch and a data read with the same extension and hold pattern have identical strobe timing and identical cycle length.
- R6: In a write, `ad_out` carries the write data with `ad_oe` high from T2 through T3. In reads and fetches, `ad_oe` is low in those clocks.
- R7: For every cycle other than a write, `rdata` takes `ad_in` at the clock edge that ends T3. `done` is high for exactly the one clock after T3.
- R8: `mem_hold_n` passes through a two-stage synchronizer. Each time its synchronized value is low at the end of T2, or at the end of a hold clock, one hold clock is inserted before T3.
- R9: A cycle lasts 3 + extension + hold clocks, counted from T1 through T3.
- R10: If that count would exceed 10, T3 is forced so that the cycle lasts exactly 10 clocks. `timeout_err` is then high in the same clock as `done`, and it is low after all other cycles.
- R11: `xlat_fault_n` low in any clock of an active cycle sets `fault_pend` in the next clock. The input is ignored while the sequencer is idle. The next request taken runs with status 4'b0011 and `rd_wr_n` high, and it drives no write data whatever its kind. `fault_pend` clears when that request is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Core request valid |
| req_kind | input | 2 | Access kind (fetch, read, write) |
| req_seg | input | 7 | Segment number |
| req_off | input | 16 | Offset within segment |
| req_wdata | input | 16 | Write data |
| req_xtra | input | 3 | Internal extension clocks (clamped to 5) |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| mem_hold_n | input | 1 | Asynchronous hold from memory, active low |
| xlat_fault_n | input | 1 | Fault from the translation unit, active low |
| seg_o | output | 7 | Segment lines |
| ad_out | output | 16 | Address/data bus, outgoing value |
| ad_oe | output | 1 | Address/data bus output enable |
| ad_in | input | 16 | Address/data bus, incoming value |
| addr_stb_n | output | 1 | Address strobe, active low |
| data_stb_n | output | 1 | Data strobe, active low |
| rd_wr_n | output | 1 | High for read, low for write |
| bus_status | output | 4 | Cycle status code |
| rdata | output | 16 | Captured read data |
| done | output | 1 | One-clock completion pulse |
| timeout_err | output | 1 | Cycle was cut at the 10-clock limit |
| fault_pend | output | 1 | Translation fault awaiting acknowledge |

## Verification
The bench aims at the edges of the stretch arithmetic. It runs a cycle that lands on exactly ten clocks and one that overshoots by a single clock. It also runs a cycle where heavy holding meets the largest extension, and a cycle with an out-of-range extension value. An off-by-one in the cap comparison would either time out a legal ten-clock cycle or run an eleventh clock. A missing clamp would stretch the cycle past the expected end, and a missing synchronizer stage would shift every hold window by one clock. The fault path is checked by a fault during a read, followed by a write request that must come out as a fault-acknowledge read. A design that looked at the request kind here, or that did not clear the pending flag, would show the wrong status or drive data onto the bus.

// File: rtl/segbus_pkg.sv
package segbus_pkg;

    localparam int SEG_W  = 7;
    localparam int OFF_W  = 16;
    localparam int XTRA_W = 3;

    localparam logic [1:0] K_FETCH = 2'b00;
    localparam logic [1:0] K_READ  = 2'b01;
    localparam logic [1:0] K_WRITE = 2'b10;

    localparam logic [3:0] ST_IDLE      = 4'b0000;
    localparam logic [3:0] ST_DATA      = 4'b1000;
    localparam logic [3:0] ST_FETCH     = 4'b1100;
    localparam logic [3:0] ST_FAULT_ACK = 4'b0011;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_SEG  = 3'd1,
        PH_T1   = 3'd2,
        PH_TX   = 3'd3,
        PH_T2   = 3'd4,
        PH_TW   = 3'd5,
        PH_T3   = 3'd6
    } phase_e;

    typedef struct packed {
        logic [SEG_W-1:0] seg;
        logic [OFF_W-1:0] off;
        logic [OFF_W-1:0] wdata;
    } req_fields_t;

    function automatic logic [3:0] status_for(input logic [1:0] kind, input logic fault);
        if (fault)
            return ST_FAULT_ACK;
        if (kind == K_FETCH)
            return ST_FETCH;
        return ST_DATA;
    endfunction

    function automatic logic phase_in_data(input phase_e ph);
        return (ph == PH_T2) || (ph == PH_TW) || (ph == PH_T3);
    endfunction

endpackage

// File: rtl/segbus_wsync.sv
module segbus_wsync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_n,
    output logic sync_n
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= async_n;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= {chain[STAGES-2:0], async_n};
            end
        end
    endgenerate

    assign sync_n = chain[STAGES-1];
endmodule

// File: rtl/segbus_ctl.sv
module segbus_ctl
    import segbus_pkg::*;
#(
    parameter int MAX_CLK = 10,
    parameter int MAX_EXT = 5,
    parameter int XW      = XTRA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic [1:0]    req_kind,
    input  logic [XW-1:0] req_xtra,
    input  logic          hold_sn,
    input  logic          fault_n,
    output phase_e        phase,
    output logic          accept,
    output logic          req_ready,
    output logic          is_write,
    output logic [3:0]    status,
    output logic          done,
    output logic          timeout_err,
    output logic          fault_pend
);
    localparam int CNT_W = $clog2(MAX_CLK + 1);

    phase_e        ph, nxt;
    logic [CNT_W-1:0] clk_cnt;
    logic [XW-1:0] ext_left, ext_c;
    logic          forced, tmo_q, done_q, tmo_out, pend_q, wr_q;
    logic [3:0]    stat_q;

    assign ext_c     = (req_xtra > XW'(MAX_EXT)) ? XW'(MAX_EXT) : req_xtra;
    assign req_ready = (ph == PH_IDLE);
    assign accept    = req_ready && req_valid;

    always_comb begin
        nxt    = ph;
        forced = 1'b0;
        case (ph)
            PH_IDLE: if (req_valid) nxt = PH_SEG;
            PH_SEG:  nxt = PH_T1;
            PH_T1:   nxt = (ext_left != '0) ? PH_TX : PH_T2;
            PH_TX:   nxt = (ext_left == XW'(1)) ? PH_T2 : PH_TX;
            PH_T2, PH_TW: begin
                if (!hold_sn) begin
                    if (clk_cnt >= CNT_W'(MAX_CLK - 1)) begin
                        nxt    = PH_T3;
                        forced = 1'b1;
                    end else begin
                        nxt = PH_TW;
                    end
                end else begin
                    nxt = PH_T3;
                end
            end
            PH_T3:   nxt = PH_IDLE;
            default: nxt = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph       <= PH_IDLE;
            clk_cnt  <= '0;
            ext_left <= '0;
            stat_q   <= ST_IDLE;
            wr_q     <= 1'b0;
            tmo_q    <= 1'b0;
            done_q   <= 1'b0;
            tmo_out  <= 1'b0;
            pend_q   <= 1'b0;
        end else begin
            ph      <= nxt;
            done_q  <= (ph == PH_T3);
            tmo_out <= (ph == PH_T3) && tmo_q;
            if (ph == PH_SEG)
                clk_cnt <= CNT_W'(1);
            else if (ph != PH_IDLE)
                clk_cnt <= clk_cnt + CNT_W'(1);
            if (accept) begin
                ext_left <= ext_c;
                stat_q   <= status_for(req_kind, pend_q);
                wr_q     <= (req_kind == K_WRITE) && !pend_q;
                tmo_q    <= 1'b0;
                pend_q   <= 1'b0;
            end else begin
                if (ph == PH_TX)
                    ext_left <= ext_left - XW'(1);
                if (forced)
                    tmo_q <= 1'b1;
                if (ph == PH_T3) begin
                    stat_q <= ST_IDLE;
                    wr_q   <= 1'b0;
                end
                if ((ph != PH_IDLE) && !fault_n)
                    pend_q <= 1'b1;
            end
        end
    end

    assign phase       = ph;
    assign is_write    = wr_q;
    assign status      = stat_q;
    assign done        = done_q;
    assign timeout_err = tmo_out;
    assign fault_pend  = pend_q;

    // R1: an idle sequencer never presents a cycle status
    assert_ready_idle_R1: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (status == ST_IDLE));

    // R3: leaving the extension clocks always leads into T2
    assert_ext_to_t2_R3: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_TX && ext_left == XW'(1)) |=> (ph == PH_T2));
endmodule

// File: rtl/segbus_dpath.sv
module segbus_dpath
    import segbus_pkg::*;
#(
    parameter int SW = SEG_W,
    parameter int OW = OFF_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          accept,
    input  phase_e        phase,
    input  logic          is_write,
    input  logic [SW-1:0] req_seg,
    input  logic [OW-1:0] req_off,
    input  logic [OW-1:0] req_wdata,
    input  logic [OW-1:0] ad_in,
    output logic [SW-1:0] seg_o,
    output logic [OW-1:0] ad_out,
    output logic          ad_oe,
    output logic          addr_stb_n,
    output logic          data_stb_n,
    output logic [OW-1:0] rdata
);
    typedef struct packed {
        logic [SW-1:0] seg;
        logic [OW-1:0] off;
        logic [OW-1:0] wdata;
    } hold_t;

    hold_t     held;
    logic      in_addr, in_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            held  <= '0;
            rdata <= '0;
        end else begin
            if (accept)
                held <= '{seg: req_seg, off: req_off, wdata: req_wdata};
            if ((phase == PH_T3) && !is_write)
                rdata <= ad_in;
        end
    end

    assign in_addr    = (phase == PH_T1) || (phase == PH_TX);
    assign in_data    = phase_in_data(phase);
    assign seg_o      = (phase != PH_IDLE) ? held.seg : '0;
    assign addr_stb_n = (phase != PH_T1);
    assign data_stb_n = !in_data;
    assign ad_oe      = in_addr || (in_data && is_write);
    assign ad_out     = in_addr ? held.off : ((in_data && is_write) ? held.wdata : '0);

    // R6: data strobe of a write always finds write data on the bus
    assert_wdata_on_bus_R6: assert property (@(posedge clk) disable iff (rst)
        (!data_stb_n && is_write) |-> (ad_oe && ad_out == held.wdata));
endmodule

// File: rtl/segbus_seq.sv
module segbus_seq
    import segbus_pkg::*;
#(
    parameter int SW          = SEG_W,
    parameter int OW          = OFF_W,
    parameter int XW          = XTRA_W,
    parameter int MAX_CLK     = 10,
    parameter int MAX_EXT     = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic [1:0]    req_kind,
    input  logic [SW-1:0] req_seg,
    input  logic [OW-1:0] req_off,
    input  logic [OW-1:0] req_wdata,
    input  logic [XW-1:0] req_xtra,
    output logic          req_ready,
    input  logic          mem_hold_n,
    input  logic          xlat_fault_n,
    output logic [SW-1:0] seg_o,
    output logic [OW-1:0] ad_out,
    output logic          ad_oe,
    input  logic [OW-1:0] ad_in,
    output logic          addr_stb_n,
    output logic          data_stb_n,
    output logic          rd_wr_n,
    output logic [3:0]    bus_status,
    output logic [OW-1:0] rdata,
    output logic          done,
    output logic          timeout_err,
    output logic          fault_pend
);
    phase_e phase;
    logic   hold_sn, accept, is_write;

    segbus_wsync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_n (mem_hold_n),
        .sync_n  (hold_sn)
    );

    segbus_ctl #(.MAX_CLK(MAX_CLK), .MAX_EXT(MAX_EXT), .XW(XW)) u_ctl (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_kind    (req_kind),
        .req_xtra    (req_xtra),
        .hold_sn     (hold_sn),
        .fault_n     (xlat_fault_n),
        .phase       (phase),
        .accept      (accept),
        .req_ready   (req_ready),
        .is_write    (is_write),
        .status      (bus_status),
        .done        (done),
        .timeout_err (timeout_err),
        .fault_pend  (fault_pend)
    );

    segbus_dpath #(.SW(SW), .OW(OW)) u_dp (
        .clk        (clk),
        .rst        (rst),
        .accept     (accept),
        .phase      (phase),
        .is_write   (is_write),
        .req_seg    (req_seg),
        .req_off    (req_off),
        .req_wdata  (req_wdata),
        .ad_in      (ad_in),
        .seg_o      (seg_o),
        .ad_out     (ad_out),
        .ad_oe      (ad_oe),
        .addr_stb_n (addr_stb_n),
        .data_stb_n (data_stb_n),
        .rdata      (rdata)
    );

    assign rd_wr_n = !is_write;

    // checker counter: clocks from T1 through T3 of the current cycle
    logic [7:0] len_cnt;
    always_ff @(posedge clk) begin
        if (rst)                                 len_cnt <= '0;
        else if (!addr_stb_n)                    len_cnt <= 8'd1;
        else if (len_cnt != '0 && bus_status != ST_IDLE) len_cnt <= len_cnt + 8'd1;
    end

    // R2: segment lines already settled when the address strobe falls
    assert_seg_lead_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(addr_stb_n) |-> ($stable(seg_o) && bus_status != ST_IDLE));

    // R4: status holds steady across an active cycle
    assert_status_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_status != ST_IDLE && $past(bus_status) != ST_IDLE) |-> $stable(bus_status));

    // R9: completed cycles lie between three and the cap
    assert_cycle_len_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> (len_cnt >= 8'd3 && len_cnt <= 8'(MAX_CLK)));

    // R10: a timeout is only reported with completion
    assert_tmo_with_done_R10: assert property (@(posedge clk) disable iff (rst)
        timeout_err |-> done);

    // R11: pending fault only rises after the fault input was low
    assert_fault_source_R11: assert property (@(posedge clk) disable iff (rst)
        $rose(fault_pend) |-> $past(!xlat_fault_n));
endmodule

// File: tb/sim_segbus_seq.sv
`timescale 1ns/1ps
module sim_segbus_seq;

    typedef struct packed {
        logic [1:0]  kind;
        logic [6:0]  seg;
        logic [15:0] off;
        logic [15:0] wd;
        logic [2:0]  ext;
        logic [3:0]  hw;
        logic [15:0] rd;
        logic [4:0]  fault_at;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{2'b00, 7'h12, 16'h1234, 16'h0000, 3'd0, 4'd0, 16'hA5A5, 5'd0},
        '{2'b01, 7'h7F, 16'hFFFF, 16'h0000, 3'd0, 4'd0, 16'h5A5A, 5'd0},
        '{2'b10, 7'h01, 16'h8000, 16'hBEEF, 3'd0, 4'd0, 16'h0000, 5'd0},
        '{2'b01, 7'h33, 16'h0F0F, 16'h0000, 3'd2, 4'd1, 16'h1357, 5'd0},
        '{2'b10, 7'h40, 16'h0101, 16'hCAFE, 3'd1, 4'd3, 16'h0000, 5'd0},
        '{2'b00, 7'h55, 16'hAAAA, 16'h0000, 3'd5, 4'd2, 16'h2468, 5'd0},
        '{2'b01, 7'h0A, 16'h0002, 16'h0000, 3'd5, 4'd3, 16'h9ABC, 5'd0},
        '{2'b11, 7'h6C, 16'h7777, 16'h0000, 3'd7, 4'd0, 16'h3C3C, 5'd0},
        '{2'b10, 7'h22, 16'h4444, 16'h1111, 3'd0, 4'd9, 16'h0000, 5'd0},
        '{2'b01, 7'h11, 16'h2222, 16'h0000, 3'd1, 4'd0, 16'h0F0F, 5'd3},
        '{2'b10, 7'h44, 16'h6666, 16'hDEAD, 3'd0, 4'd1, 16'h8421, 5'd0},
        '{2'b00, 7'h19, 16'h3030, 16'h0000, 3'd0, 4'd0, 16'h4242, 5'd0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'b00;
    logic [6:0]  req_seg = '0;
    logic [15:0] req_off = '0;
    logic [15:0] req_wdata = '0;
    logic [2:0]  req_xtra = '0;
    logic        mem_hold_n = 1'b1;
    logic        xlat_fault_n = 1'b1;
    logic [15:0] ad_in = '0;
    logic        req_ready, ad_oe, addr_stb_n, data_stb_n, rd_wr_n;
    logic        done, timeout_err, fault_pend;
    logic [6:0]  seg_o;
    logic [15:0] ad_out, rdata;
    logic [3:0]  bus_status;

    int n_chk = 0;
    int n_bad = 0;
    logic exp_pend = 1'b0;
    logic finished = 1'b0;

    always #2.5 clk = ~clk;

    segbus_seq u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
        .req_seg(req_seg), .req_off(req_off), .req_wdata(req_wdata),
        .req_xtra(req_xtra), .req_ready(req_ready), .mem_hold_n(mem_hold_n),
        .xlat_fault_n(xlat_fault_n), .seg_o(seg_o), .ad_out(ad_out),
        .ad_oe(ad_oe), .ad_in(ad_in), .addr_stb_n(addr_stb_n),
        .data_stb_n(data_stb_n), .rd_wr_n(rd_wr_n), .bus_status(bus_status),
        .rdata(rdata), .done(done), .timeout_err(timeout_err),
        .fault_pend(fault_pend)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic check_idle(input string tag);
        chk(tag, "as_n", 32'(addr_stb_n), 32'd1);
        chk(tag, "ds_n", 32'(data_stb_n), 32'd1);
        chk(tag, "rw_n", 32'(rd_wr_n), 32'd1);
        chk(tag, "status", 32'(bus_status), 32'h0);
        chk(tag, "oe", 32'(ad_oe), 32'd0);
        chk(tag, "seg", 32'(seg_o), 32'd0);
        chk(tag, "ready", 32'(req_ready), 32'd1);
        chk(tag, "done", 32'(done), 32'd0);
        chk(tag, "tmo", 32'(timeout_err), 32'd0);
    endtask

    task automatic run_vec(input vec_t v);
        int ext_e, c2, raw, total, hw;
        logic tmo, ack, wr, stable_ok, early_done;
        logic [3:0] est;
        ext_e = (v.ext > 3'd5) ? 5 : int'(v.ext);
        hw    = int'(v.hw);
        c2    = 3 + ext_e;
        raw   = 3 + ext_e + hw;
        total = (raw > 10) ? 10 : raw;
        tmo   = (raw > 10);
        ack   = exp_pend;
        wr    = !ack && (v.kind == 2'b10);
        est   = ack ? 4'b0011 : ((v.kind == 2'b00) ? 4'b1100 : 4'b1000);
        stable_ok  = 1'b1;
        early_done = 1'b0;

        @(negedge clk);
        chk("R2", "ready before request", 32'(req_ready), 32'd1);
        req_valid = 1'b1; req_kind = v.kind; req_seg = v.seg; req_off = v.off;
        req_wdata = v.wd; req_xtra = v.ext; ad_in = v.rd;
        @(posedge clk);
        for (int i = 1; i < 30; i++) begin
            @(negedge clk);
            if (i == 1) begin
                req_valid = 1'b0;
                chk("R2", "segment clock seg", 32'(seg_o), 32'(v.seg));
                chk("R2", "segment clock as_n", 32'(addr_stb_n), 32'd1);
                chk("R4", "status early", 32'(bus_status), 32'(est));
                chk("R4", "rw_n early", 32'(rd_wr_n), 32'(!wr));
                chk("R11", "pending after take", 32'(fault_pend), 32'd0);
            end
            if (i == 2) begin
                chk("R2", "T1 as_n", 32'(addr_stb_n), 32'd0);
                chk("R2", "T1 offset", 32'(ad_out), 32'(v.off));
                chk("R2", "T1 oe", 32'(ad_oe), 32'd1);
                chk("R2", "T1 seg held", 32'(seg_o), 32'(v.seg));
            end
            if (i == 3)
                chk("R2", "as_n one clock", 32'(addr_stb_n), 32'd1);
            if (i == c2 - 1)
                chk("R3", "ds_n high before T2", 32'(data_stb_n), 32'd1);
            if (i == c2) begin
                chk("R3", "ds_n low in T2", 32'(data_stb_n), 32'd0);
                chk("R6", "oe in T2", 32'(ad_oe), 32'(wr));
                if (wr) chk("R6", "write data", 32'(ad_out), 32'(v.wd));
            end
            if (i < 2 + total) begin
                if (bus_status !== est || rd_wr_n !== !wr) stable_ok = 1'b0;
                if (done !== 1'b0) early_done = 1'b1;
            end else begin
                chk("R9,R5,R8", "done at expected clock", 32'(done), 32'd1);
                chk("R10", "timeout flag", 32'(timeout_err), 32'(tmo));
                chk("R1", "status back to idle", 32'(bus_status), 32'h0);
                if (!wr) chk("R7", "read data", 32'(rdata), 32'(v.rd));
                break;
            end
            mem_hold_n   = !((i >= c2 - 2) && (i <= c2 + hw - 3));
            xlat_fault_n = !(i == int'(v.fault_at));
        end
        chk("R4", "status and rw_n stable", 32'(stable_ok), 32'd1);
        chk("R7", "no early done", 32'(early_done), 32'd0);
        if (v.fault_at != 5'd0)
            chk("R11", "fault pending set", 32'(fault_pend), 32'd1);
        exp_pend     = (v.fault_at != 5'd0);
        mem_hold_n   = 1'b1;
        xlat_fault_n = 1'b1;
        @(negedge clk);
        chk("R7", "done one clock", 32'(done), 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_idle("R1");
        chk("R1", "pending", 32'(fault_pend), 32'd0);

        // R11: fault input while idle has no effect
        xlat_fault_n = 1'b0;
        mem_hold_n   = 1'b0;
        repeat (3) @(negedge clk);
        chk("R11", "idle fault ignored", 32'(fault_pend), 32'd0);
        xlat_fault_n = 1'b1;
        mem_hold_n   = 1'b1;
        repeat (3) @(negedge clk);
        check_idle("R1");

        for (int k = 0; k < NV; k++)
            run_vec(VECS[k]);

        repeat (2) @(negedge clk);
        check_idle("R1");

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule